// File: doc/BRIEF.md
# Smart-card character receiver with error signalling

This block receives characters from a single bidirectional smart-card data line. Its clock is the card clock, and the line input is assumed to be synchronous to it. A programmable divisor sets the bit time in clock cycles. A high-to-low transition on an idle line starts bit timing. The start bit is confirmed at mid-bit. Nine more mid-bit samples then capture eight data bits and an even-parity bit.

A character with good parity is presented on `rx_data_o` together with a one-cycle `rx_valid_o` strobe. A character with bad parity raises a one-cycle `par_err_o` strobe instead. The receiver then pulls the line low for one bit time, from the middle of the first stop bit to the middle of the second. This tells the sender to repeat the character. The pad itself sits outside the block: `drive_en_o` enables the pad driver and `drive_val_o` gives the level to drive.

Top module: `sc_char_rx`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `rx_valid_o`, `par_err_o` and `drive_en_o` are 0 and `rx_data_o` is 0.
- R2: The line level is the bit value, with no inversion. The first data bit after the start bit lands in `rx_data_o[0]` and the eighth lands in `rx_data_o[7]`. Each bit is sampled at the rising clock edge where the count of edges since the start-detect edge, modulo the divisor D, equals floor(D/2)-1.
- R3: When the eight data bits plus the parity bit hold an even number of ones, `rx_valid_o` is high for exactly one cycle. That cycle immediately follows the parity sample edge, and `rx_data_o` carries the byte in it. The line is not driven.
- R4: When the count of ones is odd, `par_err_o` is high for exactly one cycle, in the same position as R3. `rx_valid_o` stays low and `rx_data_o` keeps its previous value.
- R5: After a parity error, `drive_en_o` rises at the mid-sample edge of the first stop bit (edge 10·D+floor(D/2)-1). It stays high for exactly D cycles, and `drive_val_o` is 0 whenever `drive_en_o` is high.
- R6: If the line is high again at the start bit's mid sample, reception is abandoned with no strobe, and the next falling edge starts a new character.
- R7: The divisor input is captured on the start-detect edge. Changing it during a character has no effect on that character.
- R8: Reception starts only on a high-to-low transition. A line that is held low from reset onward starts nothing until it has been seen high.
- R9: After a good character, a start bit that follows directly after the two stop bits is accepted.
- R10: Odd divisors, and the minimum divisor of 4, give the timing of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Level seen on the data line |
| bit_div_i | input | DIV_W | Bit time in clock cycles, at least 4 |
| drive_en_o | output | 1 | Enables the external pad driver |
| drive_val_o | output | 1 | Level for the pad to drive (always low) |
| rx_data_o | output | 8 | Last byte received with good parity |
| rx_valid_o | output | 1 | One-cycle strobe for a good byte |
| par_err_o | output | 1 | One-cycle strobe for a parity failure |

## Verification
A phase counter that is off by one shifts every sample point. Within the first character this produces a wrong byte or a strobe in the wrong cycle. A bit-index slip puts the strobe a whole bit time early or late. A stuck or misplaced drive window shows on `drive_en_o` in the exact cycle it diverges. Comparing every port on every cycle against an arithmetic timing model therefore exposes these faults at the first differing cycle, not at the end of a scenario.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;

    localparam int CHAR_BITS = 8;
    localparam int CNT_W     = $clog2(CHAR_BITS + 1);

    // Level the pad is asked to drive during the error window
    localparam logic ERR_LEVEL = 1'b0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_GUARD_WAIT,
        ST_GUARD_DRIVE
    } rx_state_e;

    typedef struct packed {
        logic [CHAR_BITS-1:0] data;
        logic                 valid;
        logic                 err;
    } rx_result_t;

    // True when data plus parity carry an even number of ones
    function automatic logic parity_ok(input logic [CHAR_BITS-1:0] d, input logic p);
        return ~(^{d, p});
    endfunction

endpackage

// File: rtl/sc_bit_timer.sv
module sc_bit_timer #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             mid_o
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] half;
    logic             wrap;

    assign half  = div_q >> 1;
    assign wrap  = (phase_q == div_q - ONE);
    assign mid_o = run_i && (phase_q == half - ONE);

    // The start-detect edge closes the first cycle of the start bit
    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            phase_q <= '0;
        end else if (start_i) begin
            div_q   <= div_i;
            phase_q <= ONE;
        end else if (run_i) begin
            phase_q <= wrap ? '0 : phase_q + ONE;
        end
    end
endmodule

// File: rtl/sc_rx_shifter.sv
module sc_rx_shifter
    import sc_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear_i,
    input  logic                 shift_i,
    input  logic                 bit_i,
    output logic [CHAR_BITS-1:0] data_o,
    output logic [CNT_W-1:0]     count_o
);
    logic [CHAR_BITS-1:0] sh_q;
    logic [CNT_W-1:0]     cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (shift_i) begin
            // Least significant bit arrives first: enter at the top, move down
            sh_q  <= {bit_i, sh_q[CHAR_BITS-1:1]};
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign data_o  = sh_q;
    assign count_o = cnt_q;
endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx
    import sc_rx_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 line_i,
    input  logic [DIV_W-1:0]     bit_div_i,
    output logic                 drive_en_o,
    output logic                 drive_val_o,
    output logic [CHAR_BITS-1:0] rx_data_o,
    output logic                 rx_valid_o,
    output logic                 par_err_o
);
    rx_state_e            state_q, state_d;
    rx_result_t           res_q, res_d;
    logic                 line_q;
    logic                 drive_q, drive_d;
    logic                 start, run, mid;
    logic                 clear, shift;
    logic [CHAR_BITS-1:0] sh_data;
    logic [CNT_W-1:0]     sh_count;

    assign start = (state_q == ST_IDLE) && line_q && !line_i;
    assign run   = (state_q != ST_IDLE);

    sc_bit_timer #(.DIV_W(DIV_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start_i(start),
        .run_i  (run),
        .div_i  (bit_div_i),
        .mid_o  (mid)
    );

    sc_rx_shifter u_shift (
        .clk    (clk),
        .rst    (rst),
        .clear_i(clear),
        .shift_i(shift),
        .bit_i  (line_i),
        .data_o (sh_data),
        .count_o(sh_count)
    );

    always_comb begin
        state_d   = state_q;
        drive_d   = drive_q;
        clear     = 1'b0;
        shift     = 1'b0;
        res_d     = res_q;
        res_d.valid = 1'b0;
        res_d.err   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_START;
                    clear   = 1'b1;
                end
            end
            ST_START: begin
                if (mid) state_d = line_i ? ST_IDLE : ST_DATA;
            end
            ST_DATA: begin
                if (mid) begin
                    shift = 1'b1;
                    if (sh_count == CNT_W'(CHAR_BITS - 1)) state_d = ST_PARITY;
                end
            end
            ST_PARITY: begin
                if (mid) begin
                    if (parity_ok(sh_data, line_i)) begin
                        res_d.data  = sh_data;
                        res_d.valid = 1'b1;
                        state_d     = ST_IDLE;
                    end else begin
                        res_d.err = 1'b1;
                        state_d   = ST_GUARD_WAIT;
                    end
                end
            end
            ST_GUARD_WAIT: begin
                if (mid) begin
                    drive_d = 1'b1;
                    state_d = ST_GUARD_DRIVE;
                end
            end
            ST_GUARD_DRIVE: begin
                if (mid) begin
                    drive_d = 1'b0;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            res_q   <= '0;
            drive_q <= 1'b0;
            line_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            res_q   <= res_d;
            drive_q <= drive_d;
            line_q  <= line_i;
        end
    end

    assign drive_en_o  = drive_q;
    assign drive_val_o = ERR_LEVEL;
    assign rx_data_o   = res_q.data;
    assign rx_valid_o  = res_q.valid;
    assign par_err_o   = res_q.err;
endmodule

// File: rtl/sc_char_rx_chk.sv
module sc_char_rx_chk
    import sc_rx_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 drive_en,
    input logic                 drive_val,
    input logic [CHAR_BITS-1:0] rx_data,
    input logic                 rx_valid,
    input logic                 par_err
);
    logic err_pending;

    always_ff @(posedge clk) begin
        if (rst)           err_pending <= 1'b0;
        else if (par_err)  err_pending <= 1'b1;
        else if (drive_en) err_pending <= 1'b0;
    end

    assert_valid_single_R3: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    assert_err_single_R4: assert property (@(posedge clk) disable iff (rst)
        par_err |=> !par_err);

    assert_err_no_valid_R4: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && par_err));

    assert_data_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> $stable(rx_data));

    assert_drive_low_R5: assert property (@(posedge clk) disable iff (rst)
        drive_en |-> !drive_val);

    assert_drive_needs_err_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_en) |-> err_pending);

    assert_drive_not_at_err_R5: assert property (@(posedge clk) disable iff (rst)
        par_err |=> !drive_en);

    assert_quiet_while_drive_R5: assert property (@(posedge clk) disable iff (rst)
        drive_en |-> (!rx_valid && !par_err));
endmodule

bind sc_char_rx sc_char_rx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .drive_en (drive_en_o),
    .drive_val(drive_val_o),
    .rx_data  (rx_data_o),
    .rx_valid (rx_valid_o),
    .par_err  (par_err_o)
);

// File: tb/test_sc_char_rx.sv
`timescale 1ns/1ps
module test_sc_char_rx;
    localparam int DIV_W = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             src = 1'b0;
    logic [DIV_W-1:0] bit_div = 12'd8;
    logic             line;
    logic             drive_en, drive_val, rx_valid, par_err;
    logic [7:0]       rx_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    // Open-drain style line: the receiver's drive pulls it low
    assign line = src & ~(drive_en & ~drive_val);

    sc_char_rx #(.DIV_W(DIV_W)) i_sc_char_rx (
        .clk        (clk),
        .rst        (rst),
        .line_i     (line),
        .bit_div_i  (bit_div),
        .drive_en_o (drive_en),
        .drive_val_o(drive_val),
        .rx_data_o  (rx_data),
        .rx_valid_o (rx_valid),
        .par_err_o  (par_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Arithmetic timing model: edge count since start detect
    int         m_mode = 0, m_t = 0, m_D = 8;
    logic       m_prev = 1'b0;
    logic [11:0] m_bits = '0;
    logic       e_valid = 0, e_err = 0, e_drive = 0;
    logic [7:0] e_data = '0;

    always @(posedge clk) begin
        logic ln;
        int   n;
        if (rst) begin
            m_mode = 0; m_prev = 1'b0;
            e_valid = 0; e_err = 0; e_drive = 0; e_data = '0;
        end else begin
            ln = line;
            e_valid = 0; e_err = 0;
            case (m_mode)
                0: if (m_prev && !ln) begin m_mode = 1; m_t = 0; m_D = int'(bit_div); end
                1: begin
                    m_t++;
                    if (m_t % m_D == m_D / 2 - 1) begin
                        n = m_t / m_D;
                        m_bits[n] = ln;
                        if (n == 0 && ln) m_mode = 0;
                        else if (n == 9) begin
                            if ($countones(m_bits[9:1]) % 2 == 0) begin
                                e_valid = 1; e_data = m_bits[8:1]; m_mode = 0;
                            end else begin
                                e_err = 1; m_mode = 2;
                            end
                        end
                    end
                end
                default: begin
                    m_t++;
                    if (m_t == 10 * m_D + m_D / 2 - 1) e_drive = 1;
                    if (m_t == 11 * m_D + m_D / 2 - 1) begin e_drive = 0; m_mode = 0; end
                end
            endcase
            m_prev = ln;
        end
    end

    int         n_valid = 0, n_err = 0;
    logic [7:0] last_data = '0;

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(rx_valid == e_valid, "R3 valid strobe", rx_valid, e_valid);
            check(par_err == e_err, "R4 error strobe", par_err, e_err);
            check(drive_en == e_drive, "R5 drive window", drive_en, e_drive);
            check(rx_data == e_data, "R2 data bits", rx_data, e_data);
            if (drive_en) check(drive_val == 1'b0, "R5 drive level", drive_val, 0);
            if (rx_valid) begin n_valid++; last_data = rx_data; end
            if (par_err) n_err++;
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drives one character; chg_at >= 0 switches the divisor input at that bit
    task automatic send_char(input logic [7:0] d, input bit bad, input int D,
                             input int stops, input int chg_at, input int alt);
        logic [11:0] lv;
        int total;
        total = 10 + stops;
        lv = '1;
        lv[0] = 1'b0;
        lv[8:1] = d;
        lv[9] = (^d) ^ bad;
        for (int i = 0; i < total; i++) begin
            if (i == chg_at) bit_div = DIV_W'(alt);
            src = (i < 10) ? lv[i] : 1'b1;
            wait_cycles(D);
        end
    endtask

    task automatic expect_counts(input string req, input int v0, input int e0,
                                 input int dv, input int de, input logic [7:0] data);
        check(n_valid - v0 == dv, req, n_valid - v0, dv);
        check(n_err - e0 == de, req, n_err - e0, de);
        if (dv > 0) check(last_data == data, req, last_data, data);
    endtask

    initial begin
        int v0, e0;
        wait_cycles(5);
        // R1: reset state
        check(rx_valid == 0 && par_err == 0 && drive_en == 0 && rx_data == 0,
              "R1 reset outputs", {rx_valid, par_err, drive_en}, 0);
        rst = 1'b0;
        wait_cycles(1);
        check(rx_valid == 0 && par_err == 0 && drive_en == 0, "R1 after reset",
              {rx_valid, par_err, drive_en}, 0);

        // R8: line low from reset must not start a character
        v0 = n_valid; e0 = n_err;
        wait_cycles(60);
        src = 1'b1;
        wait_cycles(20);
        expect_counts("R8 no start without edge", v0, e0, 0, 0, 8'h00);

        // R2 R3: basic good character
        v0 = n_valid; e0 = n_err;
        send_char(8'hA5, 0, 8, 2, -1, 0);
        wait_cycles(10);
        expect_counts("R2 R3 byte A5", v0, e0, 1, 0, 8'hA5);

        // R9: back-to-back characters, divisor 10
        bit_div = 12'd10;
        v0 = n_valid; e0 = n_err;
        send_char(8'h01, 0, 10, 2, -1, 0);
        check(n_valid - v0 == 1 && last_data == 8'h01, "R9 first of pair", last_data, 8'h01);
        send_char(8'hFE, 0, 10, 2, -1, 0);
        wait_cycles(10);
        expect_counts("R9 second of pair", v0, e0, 2, 0, 8'hFE);

        // R4 R5: parity error, error window, then repeat
        bit_div = 12'd8;
        v0 = n_valid; e0 = n_err;
        send_char(8'h3C, 1, 8, 3, -1, 0);
        expect_counts("R4 bad parity flagged", v0, e0, 0, 1, 8'h00);
        check(rx_data == 8'hFE, "R4 data held", rx_data, 8'hFE);
        send_char(8'h3C, 0, 8, 2, -1, 0);
        wait_cycles(10);
        expect_counts("R5 repeat accepted", v0, e0, 1, 1, 8'h3C);

        // R6: short low pulse is rejected, then a real character
        v0 = n_valid; e0 = n_err;
        src = 1'b0;
        wait_cycles(2);
        src = 1'b1;
        wait_cycles(30);
        expect_counts("R6 glitch ignored", v0, e0, 0, 0, 8'h00);
        send_char(8'h5A, 0, 8, 2, -1, 0);
        wait_cycles(10);
        expect_counts("R6 after glitch", v0, e0, 1, 0, 8'h5A);

        // R7: divisor input changes mid-character
        v0 = n_valid; e0 = n_err;
        send_char(8'hC3, 0, 8, 2, 3, 20);
        bit_div = 12'd8;
        wait_cycles(10);
        expect_counts("R7 divisor latched", v0, e0, 1, 0, 8'hC3);

        // R10: odd divisor and minimum divisor, including an error at D=4
        bit_div = 12'd5;
        v0 = n_valid; e0 = n_err;
        send_char(8'h96, 0, 5, 2, -1, 0);
        wait_cycles(10);
        expect_counts("R10 odd divisor", v0, e0, 1, 0, 8'h96);
        bit_div = 12'd4;
        v0 = n_valid; e0 = n_err;
        send_char(8'h69, 0, 4, 2, -1, 0);
        send_char(8'h0F, 1, 4, 3, -1, 0);
        send_char(8'h0F, 0, 4, 2, -1, 0);
        wait_cycles(10);
        expect_counts("R10 minimum divisor", v0, e0, 2, 1, 8'h0F);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule